// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

An eight-pin general-purpose I/O port sitting behind a simple 32-bit register bus with a 4 KB window. Every pin can be switched between input and output. The port also holds interrupt configuration, an interrupt status register, an alternate-function selector, eight pad-control scratch registers and a read-only identification window.

The data register is reached through an address-encoded mask. Any access below offset 0x400 is a data access, and word-address bits [9:2] select which pins that access touches. Software can therefore set or sample any subset of pins in a single bus cycle, with no read-modify-write. A pin configured as input drives its output high and copies its synchronized external level into its data bit. Each pin has an interrupt detector that can run in level, single-edge or both-edge mode. The detectors' masked results are ORed onto one interrupt line.

Reads are combinational from the registers, so read data is valid in the same cycle as the address. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `gpio_maskport`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. As a result, all pins are inputs, `pin_out` is 8'hFF, `irq` is 0 and the configuration registers read 0.
- R2: A read at any offset below 0x400 returns the data register ANDed with address bits [9:2]. Bit i of the mask is address bit i+2, and bits [31:8] of the result are zero.
- R3: A write below 0x400 changes data bit i only when address bit i+2 is 1 and direction bit i is 1. It then takes `bus_wdata[i]`. Every other output data bit keeps its value.
- R4: `pin_out[i]` equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R5: For a pin whose direction bit is 0, the data bit takes the value `pin_in` had three clock edges earlier: two synchronizer flops, then the data register.
- R6: The following registers read back the low 8 bits last written, with bits [31:8] read as zero: direction at 0x400 (1 = output), sense at 0x404, both-edges at 0x408, polarity at 0x40C, mask at 0x410, alternate-function at 0x420, and eight pad registers at 0x500 to 0x51C.
- R7: Raw status at 0x414 latches each detector hit, one edge after the hit. Detection uses the synchronized level L and its previous value P. Sense=1 is level mode: polarity 1 hits on L=1 and polarity 0 on L=0. Sense=0 is edge mode: both-edges 1 hits on L≠P. Otherwise polarity 1 hits on the rising edge and polarity 0 on the falling edge.
- R8: Masked status at 0x418 reads raw status AND mask, and `irq` is 1 exactly when that value is non-zero.
- R9: A write to 0x41C clears every raw status bit written as 1. A detector hit in the same cycle keeps its bit set.
- R10: Offsets 0xFD0 to 0xFFC read one identification byte per word: 00,00,00,00,61,00,18,01,0D,F0,05,B1, in increasing address order.
- R11: Unmapped offsets read zero and writes to them change no register. Writes to 0x414, 0x418 and the identification window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Resolved pin drive levels |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its defaults: 8 pins, a 2-flop synchronizer and 8 pad registers. These values reach every 8-bit address mask, every pad slot and the full identification window. A behavioural model advances with the same inputs and is compared on every clock against read data, pin drive and interrupt. The stimulus covers direction patterns that are all-input, all-output and mixed, each detector mode on toggling inputs, clears that race a hit, and a long random mix of bus and pin traffic.

// File: rtl/gpio_mp_pkg.sv
// Shared constants for the address-masked GPIO port: word addresses of the
// register map and the identification byte lookup.
package gpio_mp_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WA_W   = ADDR_W - 2;

    // Word addresses (byte offset >> 2)
    localparam logic [WA_W-1:0] WA_DIR   = 10'h100;
    localparam logic [WA_W-1:0] WA_SENSE = 10'h101;
    localparam logic [WA_W-1:0] WA_BOTH  = 10'h102;
    localparam logic [WA_W-1:0] WA_POL   = 10'h103;
    localparam logic [WA_W-1:0] WA_MASK  = 10'h104;
    localparam logic [WA_W-1:0] WA_RAW   = 10'h105;
    localparam logic [WA_W-1:0] WA_MST   = 10'h106;
    localparam logic [WA_W-1:0] WA_CLR   = 10'h107;
    localparam logic [WA_W-1:0] WA_ALT   = 10'h108;
    localparam logic [WA_W-1:0] WA_PAD   = 10'h140;
    localparam logic [WA_W-1:0] WA_ID    = 10'h3F4;
    localparam int unsigned     ID_WORDS = 12;

    // Identification byte for word index idx within the ID window
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd4:    id_byte = 8'h61;
            4'd6:    id_byte = 8'h18;
            4'd7:    id_byte = 8'h01;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/gpio_mp_sync.sv
// Multi-flop synchronizer for the pin inputs.
// Assumes: STAGES >= 2; every bit is treated independently (no bus coherence).
module gpio_mp_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage;

    // Shift the pin levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
        end else begin
            stage[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                stage[k] <= stage[k-1];
            end
        end
    end

    assign q = stage[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            // R5: last stage is the previous value of the one before it
            p_sync_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stage[STAGES-1] == $past(stage[STAGES-2])))
                else $error("sync chain broken");
        end
    endgenerate
endmodule

// File: rtl/gpio_mp_irq.sv
// Per-pin interrupt detectors and the raw status register.
// Assumes: lvl is already synchronized; clear and set may coincide, set wins.
module gpio_mp_irq #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] both,
    input  logic [W-1:0] pol,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] hit,
    output logic [W-1:0] raw
);
    logic [W-1:0] prev;

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_det
            logic rise, fall, lvl_hit, edge_hit;
            assign rise     = lvl[i] & ~prev[i];
            assign fall     = ~lvl[i] & prev[i];
            assign lvl_hit  = pol[i] ? lvl[i] : ~lvl[i];
            assign edge_hit = both[i] ? (rise | fall) : (pol[i] ? rise : fall);
            assign hit[i]   = sense[i] ? lvl_hit : edge_hit;
        end
    endgenerate

    // Latch hits into raw status; write-one-to-clear, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~(clr_en ? clr_mask : '0)) | hit;
    end

    // R7: a hit is latched on the next edge
    p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((raw & $past(hit)) == $past(hit)))
        else $error("hit not latched");

    // R7: without hit or clear, status holds
    p_raw_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !clr_en) |=> $stable(raw))
        else $error("raw status drifted");

    // R9: cleared bits with no concurrent hit go to zero
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((raw & $past(clr_mask & ~hit)) == '0))
        else $error("clear failed");
endmodule

// File: rtl/gpio_mp_ctrl.sv
// Configuration register bank: direction, interrupt setup, mask, alternate
// function and pad scratch registers, plus the clear strobe decode.
// Assumes: one access per cycle; word-aligned decode (address bits [1:0] ignored).
module gpio_mp_ctrl
    import gpio_mp_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned PADS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WA_W-1:0] waddr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    dir,
    output logic [W-1:0]    sense,
    output logic [W-1:0]    both,
    output logic [W-1:0]    pol,
    output logic [W-1:0]    mask,
    output logic            clr_en,
    output logic [W-1:0]    clr_mask,
    output logic            rd_hit,
    output logic [W-1:0]    rd_data
);
    localparam int unsigned IDX_W = (PADS > 1) ? $clog2(PADS) : 1;

    logic [W-1:0]            alt;
    logic [PADS-1:0][W-1:0]  pad_arr;
    logic                    pad_sel;
    logic [IDX_W-1:0]        pad_idx;

    assign pad_idx = waddr[IDX_W-1:0];
    assign pad_sel = (waddr[WA_W-1:IDX_W] == WA_PAD[WA_W-1:IDX_W])
                     && (int'(pad_idx) < PADS);

    // Write the interrupt and direction configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= '0;
            sense <= '0;
            both  <= '0;
            pol   <= '0;
            mask  <= '0;
            alt   <= '0;
        end else if (wr_en) begin
            case (waddr)
                WA_DIR:   dir   <= wdata;
                WA_SENSE: sense <= wdata;
                WA_BOTH:  both  <= wdata;
                WA_POL:   pol   <= wdata;
                WA_MASK:  mask  <= wdata;
                WA_ALT:   alt   <= wdata;
                default:  ;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < PADS; p++) begin : g_pad
            logic [W-1:0] q;
            // Pad scratch register p
            always_ff @(posedge clk) begin
                if (!rst_n)                                        q <= '0;
                else if (wr_en && pad_sel && int'(pad_idx) == p)   q <= wdata;
            end
            assign pad_arr[p] = q;
        end
    endgenerate

    // Clear strobe for the raw status register
    assign clr_en   = wr_en && (waddr == WA_CLR);
    assign clr_mask = wdata;

    // Readback of configuration and pad registers
    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        case (waddr)
            WA_DIR:   rd_data = dir;
            WA_SENSE: rd_data = sense;
            WA_BOTH:  rd_data = both;
            WA_POL:   rd_data = pol;
            WA_MASK:  rd_data = mask;
            WA_ALT:   rd_data = alt;
            default: begin
                if (pad_sel) rd_data = pad_arr[pad_idx];
                else         rd_hit  = 1'b0;
            end
        endcase
    end

    // R6: a direction write is visible on the next cycle
    p_dir_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == WA_DIR) |=> (dir == $past(wdata)))
        else $error("direction write lost");
endmodule

// File: rtl/gpio_mp_data.sv
// Data register with address-masked writes and input capture, plus output
// resolution (input pins drive high).
// Assumes: sync_lvl is the synchronized pin level; dir=1 means output.
module gpio_mp_data #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] amask,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] sync_lvl,
    output logic [W-1:0] data_q,
    output logic [W-1:0] pin_out
);
    logic [W-1:0] upd;

    assign upd = wr_en ? (amask & dir) : '0;

    // Output bits take masked writes; input bits follow the synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= (dir & ((data_q & ~upd) | (wdata & upd))) | (~dir & sync_lvl);
    end

    // Drive outputs; inputs float high
    assign pin_out = (data_q & dir) | ~dir;

    // R3: output bits outside the address mask are left alone by a write
    p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((data_q & $past(dir & ~amask)) == ($past(data_q) & $past(dir & ~amask))))
        else $error("unmasked data bit changed");

    // R5: input bits carry the previous synchronized level
    p_input_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((data_q & ~$past(dir)) == ($past(sync_lvl) & ~$past(dir))))
        else $error("input capture wrong");
endmodule

// File: rtl/gpio_maskport.sv
// Top level of the address-masked GPIO port: bus decode, read mux and the
// identification window; wires synchronizer, data, control and interrupt logic.
// Assumes: combinational read data; one access per cycle; PINS <= 8 fits the map.
module gpio_maskport
    import gpio_mp_pkg::*;
#(
    parameter int unsigned PINS        = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PAD_REGS    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic              irq
);
    logic [WA_W-1:0] waddr;
    logic            in_data, in_id;
    logic [PINS-1:0] amask, wbyte;
    logic [PINS-1:0] sync_lvl, data_q;
    logic [PINS-1:0] dir, sense, both, pol, mask, clr_mask;
    logic [PINS-1:0] hit, raw, masked;
    logic            clr_en, ctrl_hit;
    logic [PINS-1:0] ctrl_rdata;
    logic [WA_W-1:0] id_off;
    logic            unused_ok;

    assign waddr   = bus_addr[ADDR_W-1:2];
    assign in_data = (waddr[WA_W-1:PINS] == '0);
    assign amask   = waddr[PINS-1:0];
    assign wbyte   = bus_wdata[PINS-1:0];
    assign in_id   = (waddr >= WA_ID);
    assign id_off  = waddr - WA_ID;
    assign masked  = raw & mask;
    assign irq     = |masked;
    assign unused_ok = ^{bus_wdata, bus_addr[1:0]};

    gpio_mp_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_lvl)
    );

    gpio_mp_data #(.W(PINS)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && in_data), .amask(amask),
        .wdata(wbyte), .dir(dir), .sync_lvl(sync_lvl), .data_q(data_q),
        .pin_out(pin_out)
    );

    gpio_mp_ctrl #(.W(PINS), .PADS(PAD_REGS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr && !in_data), .waddr(waddr),
        .wdata(wbyte), .dir(dir), .sense(sense), .both(both), .pol(pol),
        .mask(mask), .clr_en(clr_en), .clr_mask(clr_mask),
        .rd_hit(ctrl_hit), .rd_data(ctrl_rdata)
    );

    gpio_mp_irq #(.W(PINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .sense(sense), .both(both),
        .pol(pol), .clr_en(clr_en), .clr_mask(clr_mask), .hit(hit), .raw(raw)
    );

    // Select read data by region: masked data, status, config, ID, else zero
    always_comb begin
        bus_rdata = '0;
        if (in_data)                  bus_rdata[PINS-1:0] = data_q & amask;
        else if (waddr == WA_RAW)     bus_rdata[PINS-1:0] = raw;
        else if (waddr == WA_MST)     bus_rdata[PINS-1:0] = masked;
        else if (ctrl_hit)            bus_rdata[PINS-1:0] = ctrl_rdata;
        else if (in_id && int'(id_off) < ID_WORDS)
                                      bus_rdata[7:0]      = id_byte(id_off[3:0]);
    end

    // R8: an enabled hit raises irq on the next cycle unless the mask is rewritten
    p_irq_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (((hit & mask) != '0) && !(bus_wr && waddr == WA_MASK)) |=> irq)
        else $error("irq missed an enabled hit");
endmodule

// File: tb/tb_gpio_maskport.sv
`timescale 1ns/1ps
module tb_gpio_maskport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;
    logic        irq;

    gpio_maskport dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .irq(irq)
    );

    always #4 clk = ~clk;   // 125 MHz

    int nchk = 0, nbad = 0;
    bit done = 0;
    string tag_ovr = "";
    int idb[12] = '{'h00, 'h00, 'h00, 'h00, 'h61, 'h00, 'h18, 'h01, 'h0D, 'hF0, 'h05, 'hB1};

    // Behavioural reference state
    int m_data, m_dir, m_sense, m_both, m_pol, m_mask, m_alt, m_raw;
    int m_s1, m_s2, m_prev;
    int m_pad[8];

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int mread(input int addr);
        int a;
        a = addr & 'hFFC;
        if (a < 'h400) return m_data & ((a >> 2) & 'hFF);
        case (a)
            'h400: return m_dir;
            'h404: return m_sense;
            'h408: return m_both;
            'h40C: return m_pol;
            'h410: return m_mask;
            'h414: return m_raw;
            'h418: return m_raw & m_mask;
            'h420: return m_alt;
            default: begin
                if (a >= 'h500 && a < 'h520) return m_pad[(a - 'h500) >> 2];
                if (a >= 'hFD0) return idb[(a - 'hFD0) >> 2];
                return 0;
            end
        endcase
    endfunction

    function automatic string tag_for(input int addr);
        int a;
        a = addr & 'hFFC;
        if (tag_ovr != "") return tag_ovr;
        if (a < 'h400) begin
            if (m_dir == 0) return "R5";
            if (m_dir == 'hFF) return "R3";
            return "R2";
        end
        if (a == 'h414) return "R7";
        if (a == 'h418) return "R8";
        if ((a >= 'h400 && a <= 'h420 && a != 'h41C) || (a >= 'h500 && a < 'h520)) return "R6";
        if (a >= 'hFD0) return "R10";
        return "R11";
    endfunction

    // Reference model: advance one clock from the inputs driven at the last negedge
    always @(posedge clk) begin
        int a, w, hit, nd, lv, pv, h, bit_d;
        if (!rst_n) begin
            m_data = 0; m_dir = 0; m_sense = 0; m_both = 0; m_pol = 0;
            m_mask = 0; m_alt = 0; m_raw = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            for (int k = 0; k < 8; k++) m_pad[k] = 0;
        end else begin
            a = bus_addr & 'hFFC;
            w = bus_wdata & 'hFF;
            hit = 0;
            nd = 0;
            for (int i = 0; i < 8; i++) begin
                lv = (m_s2 >> i) & 1;
                pv = (m_prev >> i) & 1;
                if ((m_sense >> i) & 1)       h = ((m_pol >> i) & 1) ? lv : 1 - lv;
                else if ((m_both >> i) & 1)   h = (lv != pv) ? 1 : 0;
                else if ((m_pol >> i) & 1)    h = (lv == 1 && pv == 0) ? 1 : 0;
                else                          h = (lv == 0 && pv == 1) ? 1 : 0;
                hit |= h << i;
                if ((m_dir >> i) & 1) begin
                    bit_d = (m_data >> i) & 1;
                    if (bus_wr && a < 'h400 && (((a >> 2) >> i) & 1)) bit_d = (w >> i) & 1;
                end else begin
                    bit_d = lv;
                end
                nd |= bit_d << i;
            end
            if (bus_wr && a == 'h41C) m_raw = m_raw & ~w;
            m_raw = (m_raw | hit) & 'hFF;
            if (bus_wr) begin
                case (a)
                    'h400: m_dir = w;
                    'h404: m_sense = w;
                    'h408: m_both = w;
                    'h40C: m_pol = w;
                    'h410: m_mask = w;
                    'h420: m_alt = w;
                    default: if (a >= 'h500 && a < 'h520) m_pad[(a - 'h500) >> 2] = w;
                endcase
            end
            m_data = nd;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = int'(pin_in);
        end
    end

    // Compare every cycle, away from both clock edges
    always begin
        @(negedge clk);
        #3;
        if (rst_n && !done) begin
            chk(tag_for(int'(bus_addr)), int'(bus_rdata), mread(int'(bus_addr)));
            chk("R4", int'(pin_out), (m_data & m_dir) | (~m_dir & 'hFF));
            chk("R8", int'(irq), ((m_raw & m_mask) != 0) ? 1 : 0);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[11:0]; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a);
        @(negedge clk);
        bus_addr = a[11:0];
    endtask

    task automatic pins(input int v, input int hold);
        @(negedge clk);
        pin_in = v[7:0];
        repeat (hold) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure
    initial begin
        #(8 * 60000);
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        // R1: reset state at the ports
        chk("R1", int'(pin_out), 'hFF);
        chk("R1", int'(irq), 0);
        bus_addr = 12'h400;
        #1;
        chk("R1", int'(bus_rdata), 0);

        // R10: identification window; R11: unmapped reads
        for (int k = 0; k < 12; k++) rd('hFD0 + 4 * k);
        rd('h424); rd('h600); rd('hFCC); rd('h52C);

        // R3/R4: all outputs, full-mask and partial-mask writes
        wr('h400, 'hFF);
        wr('h3FC, 'hA5); rd('h3FC);
        wr('h140, 'hFF); rd('h3FC);          // mask bits 4 and 6
        wr('h00C, 'h00); rd('h3FC);          // mask bits 0 and 1
        rd('h040); rd('h200);                // R2 partial reads
        // R2/R3 mixed direction: writes to input bits ignored
        wr('h400, 'hF0);
        wr('h3FC, 'h0F); rd('h3FC);
        pins('h3C, 5); rd('h3FC); rd('h0F0);
        // R5: all inputs following pin changes
        wr('h400, 'h00);
        pins('h55, 1); rd('h3FC); pins('hAA, 4); pins('h01, 2);

        // R7/R8: edge modes on bits 0..3, level on 4..7
        wr('h410, 'hFF);
        wr('h404, 'hF0);
        wr('h40C, 'h5A);
        wr('h408, 'h03);
        wr('h41C, 'hFF);
        rd('h414);
        pins('h0F, 5); rd('h418);
        pins('hF0, 5); rd('h414);
        wr('h41C, 'h0F);
        tag_ovr = "R9"; rd('h414); rd('h418); tag_ovr = "";
        // R9: clear racing a continuous level hit keeps the bit set
        pins('h00, 5);
        wr('h41C, 'hFF);
        tag_ovr = "R9"; rd('h414); rd('h414); tag_ovr = "";
        wr('h410, 'h00); rd('h418);

        // R6: pad registers and config readback
        for (int k = 0; k < 8; k++) wr('h500 + 4 * k, 'h11 * (k + 1) + 'h100);
        for (int k = 0; k < 8; k++) rd('h500 + 4 * k);
        wr('h420, 'h3C); rd('h420);
        // R11: writes to unmapped, status and ID locations ignored
        wr('h600, 'hFF); wr('h414, 'hFF); wr('h418, 'hFF); wr('hFD0, 'hFF); wr('h524, 'hFF);
        rd('h600); rd('h414); rd('hFD0); rd('h524);

        // Random mix of bus and pin traffic
        for (int n = 0; n < 2000; n++) begin
            int sel, a;
            @(negedge clk);
            sel = int'($urandom % 16);
            if (sel < 6) a = int'($urandom % 256) << 2;
            else begin
                case (sel)
                    6: a = 'h400; 7: a = 'h404; 8: a = 'h408; 9: a = 'h40C;
                    10: a = 'h410; 11: a = 'h414; 12: a = 'h418; 13: a = 'h41C;
                    14: a = 'h500 + 4 * int'($urandom % 8);
                    default: a = 'hFD0 + 4 * int'($urandom % 12);
                endcase
            end
            bus_addr = a[11:0];
            bus_wr = ($urandom % 3) == 0;
            bus_wdata = $urandom;
            if (($urandom % 4) == 0) pin_in = 8'($urandom);
        end
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end
endmodule